// File: doc/BRIEF.md
# Tree-Based Round-Robin Arbiter with Merged Data Select

This block picks one of `N` requesters in round-robin order and, in the same combinational pass, delivers the chosen requester's data word at its output. The usual cyclic priority search is replaced by a search for a maximum. Each input forms a two-bit unsigned symbol. The request bit is the upper bit and a stored priority bit is the lower bit. A balanced binary tree of two-input compare-and-select nodes finds the largest symbol. When symbols are equal, the node on the right side wins.

Each node also forwards the data word from the side it selects and records a one-bit direction flag. The flags on the path from root to leaf mark the winning leaf, and the one-hot grant is decoded from them. The data word that reaches the root is the winner's word. Grant, output data and output valid are combinational. Only the priority vector is held in registers. After a grant it is reloaded so that the input just served has the lowest precedence on the next cycle.

A typical use is one output port of a wormhole switch. Requesters present their request bit and data word, and the block returns who won and what is sent.

Top module: `rrmx_arbmux`

## Requirements
- R1: Index 0 is the rightmost position. The winner is the lowest-indexed requesting input whose priority bit is set. If no requesting input has its priority bit set, the winner is the lowest-indexed requesting input.
- R2: `grant` has exactly one bit set when any request is active, and no bit set when none is active.
- R3: `out_valid` is high exactly when at least one bit of `req` is high, in the same cycle.
- R4: While `out_valid` is high, `out_data` equals the slice `data_in[g*DW +: DW]` of the granted input `g`, in the same cycle.
- R5: After a clock edge at which input `g` was granted, the priority bit of each input with an index above `g` is set and every other priority bit is clear. As a result, the next winner is the first requester found by counting upward from `g+1` and wrapping to 0.
- R6: A clock edge with no active request leaves the priority state unchanged. The next arbitration then resumes after the last granted input.
- R7: After reset all priority bits are clear, so the first arbitration grants the lowest-indexed requester.
- R8: A grant bit is never set for an input whose request is low.
- R9: `N` must be a power of two no smaller than 2. Other values stop elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the priority state updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the priority state |
| req | input | N | One request bit per input |
| data_in | input | N*DW | Data words; input i occupies bits i*DW +: DW |
| grant | output | N | One-hot grant, combinational |
| out_data | output | DW | Data word of the granted input |
| out_valid | output | 1 | High when any request is active |

## Verification
Two functions can act in the same cycle: the combinational selection, which reads the current priority vector, and the registered reload of that vector from the grant being issued. The bench exercises this overlap in a loop. It first sets each possible last winner with a single request. It then applies every request pattern and checks grant and data against a cyclic-search model. Finally it raises all requests on the following cycle, so the winner there shows whether the reload, or the absence of a reload after an idle cycle, took effect at the correct edge.

// File: rtl/rrmx_pkg.sv
`timescale 1ns/1ps
package rrmx_pkg;
   // two-bit symbol: {request, priority}
   typedef logic [1:0] sym_t;

   function automatic sym_t make_sym(input logic r, input logic p);
      return {r, p};
   endfunction

   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/rrmx_node.sv
`timescale 1ns/1ps
module rrmx_node
   import rrmx_pkg::*;
#(
   parameter int DW = 8
) (
   input  sym_t          l_sym,
   input  logic [DW-1:0] l_dat,
   input  sym_t          r_sym,
   input  logic [DW-1:0] r_dat,
   output sym_t          o_sym,
   output logic [DW-1:0] o_dat,
   output logic          o_left
);
   // ties go right: left must be strictly larger
   assign o_left = (l_sym > r_sym);
   assign o_sym  = o_left ? l_sym : r_sym;
   assign o_dat  = o_left ? l_dat : r_dat;
endmodule

// File: rtl/rrmx_tree.sv
`timescale 1ns/1ps
module rrmx_tree
   import rrmx_pkg::*;
#(
   parameter int N  = 8,
   parameter int DW = 8
) (
   input  logic [2*N-1:0]  syms,
   input  logic [N*DW-1:0] dats,
   output logic [N-1:0]    grant,
   output logic [DW-1:0]   root_dat,
   output logic            root_valid
);
   localparam int NODES = 2 * N - 1;

   // heap numbering: node n has right child 2n, left child 2n+1;
   // leaf i sits at N+i, so higher indices lie to the left
   sym_t          nsym [1:NODES];
   logic [DW-1:0] ndat [1:NODES];
   logic [N-1:1]  nflag;
   logic          nsel [1:NODES];

   genvar gi;
   for (gi = 0; gi < N; gi++) begin : g_leaf
      assign nsym[N+gi] = syms[2*gi +: 2];
      assign ndat[N+gi] = dats[gi*DW +: DW];
   end

   for (gi = 1; gi < N; gi++) begin : g_node
      rrmx_node #(.DW(DW)) u_node (
         .l_sym  (nsym[2*gi+1]),
         .l_dat  (ndat[2*gi+1]),
         .r_sym  (nsym[2*gi]),
         .r_dat  (ndat[2*gi]),
         .o_sym  (nsym[gi]),
         .o_dat  (ndat[gi]),
         .o_left (nflag[gi])
      );
   end

   // walk the flags downward; root enabled only by a live request
   assign nsel[1] = nsym[1][1];
   for (gi = 2; gi <= NODES; gi++) begin : g_path
      if (gi % 2 == 1) begin : g_lft
         assign nsel[gi] = nsel[gi/2] & nflag[gi/2];
      end else begin : g_rgt
         assign nsel[gi] = nsel[gi/2] & ~nflag[gi/2];
      end
   end

   for (gi = 0; gi < N; gi++) begin : g_gnt
      assign grant[gi] = nsel[N+gi];
   end

   assign root_dat   = ndat[1];
   assign root_valid = nsym[1][1];
endmodule

// File: rtl/rrmx_prio.sv
`timescale 1ns/1ps
module rrmx_prio #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] grant,
   output logic [N-1:0] prio
);
   logic [N-1:0] therm;
   logic         any_gnt;

   // thermometer: set for every position strictly above the granted one
   always_comb begin
      therm = '0;
      for (int i = 1; i < N; i++) begin
         therm[i] = therm[i-1] | grant[i-1];
      end
   end

   assign any_gnt = |grant;

   always_ff @(posedge clk) begin
      if (!rst_n)       prio <= '0;
      else if (any_gnt) prio <= therm;
   end
endmodule

// File: rtl/rrmx_arbmux.sv
`timescale 1ns/1ps
module rrmx_arbmux
   import rrmx_pkg::*;
#(
   parameter int N  = 8,
   parameter int DW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    req,
   input  logic [N*DW-1:0] data_in,
   output logic [N-1:0]    grant,
   output logic [DW-1:0]   out_data,
   output logic            out_valid
);
   // R9: elaboration-time parameter check
   if (!is_pow2(N)) begin : g_bad_n
      $error("rrmx_arbmux: N must be a power of two >= 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("rrmx_arbmux: DW must be positive");
   end

   logic [N-1:0]   prio;
   logic [2*N-1:0] syms;

   genvar gi;
   for (gi = 0; gi < N; gi++) begin : g_sym
      assign syms[2*gi +: 2] = make_sym(req[gi], prio[gi]);
   end

   rrmx_tree #(.N(N), .DW(DW)) u_tree (
      .syms       (syms),
      .dats       (data_in),
      .grant      (grant),
      .root_dat   (out_data),
      .root_valid (out_valid)
   );

   rrmx_prio #(.N(N)) u_prio (
      .clk   (clk),
      .rst_n (rst_n),
      .grant (grant),
      .prio  (prio)
   );
endmodule

// File: rtl/rrmx_arbmux_chk.sv
`timescale 1ns/1ps
module rrmx_arbmux_chk #(
   parameter int N  = 8,
   parameter int DW = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic [N-1:0]    req,
   input logic [N*DW-1:0] data_in,
   input logic [N-1:0]    grant,
   input logic [DW-1:0]   out_data,
   input logic            out_valid,
   input logic [N-1:0]    prio
);
   logic [DW-1:0] picked;
   always_comb begin
      picked = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) picked = picked | data_in[i*DW +: DW];
      end
   end

   assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((|req) -> ($countones(grant) == 1)));

   assert_valid_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == (|req));

   assert_data_of_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data == picked));

   assert_no_repeat_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> ((grant != $past(grant)) || (req == grant)));

   assert_idle_keeps_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |=> $stable(prio));

   assert_grant_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0);
endmodule

bind rrmx_arbmux rrmx_arbmux_chk #(.N(N), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req       (req),
   .data_in   (data_in),
   .grant     (grant),
   .out_data  (out_data),
   .out_valid (out_valid),
   .prio      (prio)
);

// File: tb/rrmx_arbmux_test.sv
`timescale 1ns/1ps
module rrmx_arbmux_test;
   localparam int N  = 4;
   localparam int DW = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    req = '0;
   logic [N*DW-1:0] data_in = '0;
   logic [N-1:0]    grant;
   logic [DW-1:0]   out_data;
   logic            out_valid;

   int n_cmp  = 0;
   int n_bad  = 0;
   int ptr    = N - 1;   // model: last granted index
   bit done   = 0;

   always #10 clk = ~clk;   // 50 MHz

   rrmx_arbmux #(.N(N), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .req(req), .data_in(data_in),
      .grant(grant), .out_data(out_data), .out_valid(out_valid)
   );

   function automatic int exp_win(int last, logic [N-1:0] r);
      for (int k = 1; k <= N; k++) begin
         if (r[(last + k) % N]) return (last + k) % N;
      end
      return -1;
   endfunction

   function automatic logic [DW-1:0] word_of(int i, int salt);
      return DW'((i * 37 + salt * 5 + 3) & 255);
   endfunction

   task automatic put(input logic [N-1:0] r, input int salt);
      @(negedge clk);
      req = r;
      for (int i = 0; i < N; i++) data_in[i*DW +: DW] = word_of(i, salt);
      #2;
   endtask

   task automatic check(input string tag, input int salt);
      int w;
      logic [N-1:0] eg;
      w  = exp_win(ptr, req);
      eg = (w < 0) ? '0 : (N'(1) << w);
      n_cmp++;
      if (grant !== eg) begin
         n_bad++;
         $display("FAIL %s grant req=%b: got %b exp %b", tag, req, grant, eg);
      end
      n_cmp++;
      if (out_valid !== (w >= 0)) begin
         n_bad++;
         $display("FAIL R3 valid req=%b: got %b exp %b", req, out_valid, (w >= 0));
      end
      if (w >= 0) begin
         n_cmp++;
         if (out_data !== word_of(w, salt)) begin
            n_bad++;
            $display("FAIL R4 data req=%b: got %h exp %h", req, out_data, word_of(w, salt));
         end
      end
      @(posedge clk);
      if (w >= 0) ptr = w;   // R5 reload, R6 hold when idle
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // reset state: idle, then R7 first grant is lowest index
      put('0, 0);
      check("R2", 0);
      put('1, 1);
      check("R7", 1);
      put(4'b1010, 2);
      check("R1", 2);
      // sweep: every last-winner state x every request pattern
      for (int s = 0; s < N; s++) begin
         for (int p = 0; p < (1 << N); p++) begin
            put(N'(1) << s, p);
            check("R5", p);
            put(N'(p), p + 1);
            check("R1", p + 1);
            // all requesting: winner exposes the reload (R5) or hold (R6)
            put('1, p + 2);
            check((p == 0) ? "R6" : "R5", p + 2);
         end
      end
      // reset mid-run returns to R7 state
      @(negedge clk) rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      ptr = N - 1;
      put(4'b1100, 9);
      check("R7", 9);
      put(4'b1100, 10);
      check("R8", 10);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule